// File: doc/BRIEF.md
# Synchronous Serial Receive Controller

This block is the receive side of a clock-synchronous serial port. As clock master it generates the serial clock from the system clock through a programmable divider and samples the incoming data line. As clock slave it brings an external serial clock and the data line into the system clock domain and samples on the detected clock edges. Frames are 8 to 16 bits long and can arrive least- or most-significant bit first.

Software uses four registers on a small read/write port. In master mode the clock only runs after software reads the data register while reception is enabled. The first read is a dummy read that starts the first frame. Each later read collects a frame and also starts the next one. A stop control lets one more frame complete and then keeps the clock parked until software clears both the stop control and the enable. A frame that completes while the previous one is still unread sets an overrun flag and is discarded. Two interrupt requests, one for received data and one for overrun, are gated by a single enable.

Register map: address 0 is DATA (read-only). Address 1 is STATUS: bit0 is data-ready, bit1 is overrun. Address 2 is CTRL: bit0 receive enable, bit1 interrupt enable, bit2 stop after frame, bit3 master, bit4 MSB-first, bit5 idle-high clock. Address 3 is FORMAT: bits [4:0] hold the frame length, bits [15:8] hold the clock half-period minus one.

Top module: `ssr_rx_ctrl`

## Requirements
- R1: After reset every register reads 0, sck_out and sck_oe are low and both interrupt requests are low.
- R2: With CTRL bit3=1, a DATA read while CTRL bit0=1, STATUS bit1=0 and no frame in progress produces exactly L clock pulses on sck_out, where L is the frame length. The clock then rests at its idle level. A DATA read with CTRL bit0=0 starts no clock. sck_oe equals CTRL bit3.
- R3: When the last bit of a frame is sampled, the assembled frame is loaded into DATA and STATUS bit0 becomes 1. With CTRL bit4=0 the first received bit lands in DATA bit0. With CTRL bit4=1 it lands in DATA bit L-1. DATA bits at L and above read 0.
- R4: rx_irq equals STATUS bit0 AND CTRL bit1. ovr_irq equals STATUS bit1 AND CTRL bit1.
- R5: A read of DATA clears STATUS bit0.
- R6: In master mode, with reception enabled, a DATA read that collects a finished frame starts clocking of the next frame.
- R7: If CTRL bit2=1 when a master frame completes, the clock stays idle and DATA reads start nothing. This lasts until CTRL bit0 and bit2 have both been 0. After that, enabling reception again and reading DATA restarts the clock.
- R8: If a frame completes while STATUS bit0=1 and DATA is not being read in that cycle, STATUS bit1 is set, the new frame is dropped and DATA keeps its old value.
- R9: While STATUS bit1=1 no frame is received. Writing STATUS with bit1=0 clears the flag, and writing bit1=1 leaves it unchanged. Reception then resumes.
- R10: CTRL bit5 selects the clock idle level. Data is sampled on the edge where the clock returns to its idle level. The master half-period is FORMAT[15:8]+1 system cycles, including the delay from start to the first edge.
- R11: In slave mode, clearing CTRL bit0 makes the block ignore clock edges and discards any partly received frame. The next enabled frame starts at bit 0.
- R12: A FORMAT[4:0] value below 8 acts as 8 and a value above 16 acts as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for side effects of DATA reads) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from address) |
| sck_in | input | 1 | External serial clock used in slave mode |
| sdi | input | 1 | Serial data input |
| sck_out | output | 1 | Generated serial clock in master mode |
| sck_oe | output | 1 | Drive enable for sck_out (master mode) |
| rx_irq | output | 1 | Receive interrupt request |
| ovr_irq | output | 1 | Overrun interrupt request |

## Verification
The master path is driven with random frame lengths (including two out-of-range length codes), bit orders, idle levels and divider settings. The bench's remote transmitter changes data only on the leaving-idle edge, so sampling on the wrong edge, reversing the bit order or using the wrong length each produce a different received word. The bench also counts clock pulses and measures every half-period, which separates an extra or missing pulse from a wrong divider. In slave mode, the order of frames sent without reading apart a clean receive from an overrun, a frame dropped during overrun, and a partial frame left behind after reception is disabled mid-frame. Directed master sequences cover restart on read, the stop control and its release, and a read made with reception disabled.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
package ssr_pkg;

    // control register fields, receive enable in bit 0
    typedef struct packed {
        logic idle_high;
        logic msb_first;
        logic master;
        logic stop_after;
        logic irq_en;
        logic rx_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ADR_DATA = 2'd0,
        ADR_STAT = 2'd1,
        ADR_CTRL = 2'd2,
        ADR_FMT  = 2'd3
    } reg_addr_e;

    localparam int unsigned CTRL_W  = $bits(ctrl_t);
    localparam int unsigned DIV_LSB = 8;

endpackage

// File: rtl/ssr_clkgen.sv
`timescale 1ns/1ps
module ssr_clkgen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    input  logic             idle_high_i,
    output logic             sck_o,
    output logic             trail_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             phase;   // 1 while clock is away from idle
    } cg_t;

    cg_t  cg_q, cg_d;
    logic tick;

    always_comb begin
        cg_d = cg_q;
        tick = run_i && (cg_q.cnt == half_i);
        if (!run_i) begin
            cg_d = '0;
        end else if (tick) begin
            cg_d.cnt   = '0;
            cg_d.phase = ~cg_q.phase;
        end else begin
            cg_d.cnt = cg_q.cnt + DIV_W'(1);
        end
        trail_o = tick && cg_q.phase;
        sck_o   = cg_q.phase ^ idle_high_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cg_q <= '0;
        else        cg_q <= cg_d;
    end
endmodule

// File: rtl/ssr_sync_edge.sv
`timescale 1ns/1ps
module ssr_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sdi_i,
    input  logic idle_high_i,
    output logic sdi_o,
    output logic trail_o
);
    typedef struct packed {
        logic sck_m;
        logic sck_s;
        logic sck_p;
        logic sdi_m;
        logic sdi_s;
    } sy_t;

    sy_t sy_q, sy_d;

    always_comb begin
        sy_d.sck_m = sck_i;
        sy_d.sck_s = sy_q.sck_m;
        sy_d.sck_p = sy_q.sck_s;
        sy_d.sdi_m = sdi_i;
        sy_d.sdi_s = sy_q.sdi_m;
        // edge back to the idle level is the sampling edge
        trail_o = (sy_q.sck_s != sy_q.sck_p) && (sy_q.sck_s == idle_high_i);
        sdi_o   = sy_q.sdi_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end
endmodule

// File: rtl/ssr_shifter.sv
`timescale 1ns/1ps
module ssr_shifter #(
    parameter int unsigned MAX_LEN = 16,
    parameter int unsigned LEN_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               sample_i,
    input  logic               bit_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               msb_first_i,
    output logic               done_o,
    output logic [MAX_LEN-1:0] frame_o
);
    typedef struct packed {
        logic [LEN_W-1:0]   cnt;
        logic [MAX_LEN-1:0] sh;
    } sh_t;

    sh_t                sh_q, sh_d;
    logic [LEN_W-1:0]   last_idx;
    logic [LEN_W-1:0]   pos;
    logic [MAX_LEN-1:0] merged;

    always_comb begin
        sh_d     = sh_q;
        last_idx = len_i - LEN_W'(1);
        pos      = msb_first_i ? (last_idx - sh_q.cnt) : sh_q.cnt;
        merged   = (sh_q.cnt == '0) ? '0 : sh_q.sh;
        for (int i = 0; i < MAX_LEN; i++) begin
            if (pos == LEN_W'(i)) merged[i] = bit_i;
        end
        done_o  = sample_i && (sh_q.cnt >= last_idx);
        frame_o = merged;
        if (clear_i) begin
            sh_d.cnt = '0;
        end else if (sample_i) begin
            sh_d.sh  = merged;
            sh_d.cnt = done_o ? '0 : sh_q.cnt + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/ssr_rx_ctrl.sv
`timescale 1ns/1ps
module ssr_rx_ctrl
    import ssr_pkg::*;
#(
    parameter int unsigned MIN_LEN = 8,
    parameter int unsigned MAX_LEN = 16,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned REG_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sck_in,
    input  logic             sdi,
    output logic             sck_out,
    output logic             sck_oe,
    output logic             rx_irq,
    output logic             ovr_irq
);
    localparam int unsigned LEN_W = $clog2(MAX_LEN + 1);

    typedef struct packed {
        ctrl_t              ctrl;
        logic [LEN_W-1:0]   len_f;
        logic [DIV_W-1:0]   half;
        logic [MAX_LEN-1:0] data;
        logic               ready;
        logic               ovr;
        logic               active;
        logic               halt;
    } st_t;

    st_t                s_q, s_d;
    logic [LEN_W-1:0]   eff_len;
    logic               data_rd;
    logic               mst_start;
    logic               sample;
    logic               shf_clear;
    logic               rx_bit;
    logic               frame_done;
    logic [MAX_LEN-1:0] frame_val;
    logic               m_trail;
    logic               s_trail;
    logic               s_sdi;
    logic               unused_wbits;

    assign unused_wbits = ^reg_wdata;

    ssr_clkgen #(.DIV_W(DIV_W)) clkgen_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (s_q.active),
        .half_i     (s_q.half),
        .idle_high_i(s_q.ctrl.idle_high),
        .sck_o      (sck_out),
        .trail_o    (m_trail)
    );

    ssr_sync_edge sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_i      (sck_in),
        .sdi_i      (sdi),
        .idle_high_i(s_q.ctrl.idle_high),
        .sdi_o      (s_sdi),
        .trail_o    (s_trail)
    );

    ssr_shifter #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) shifter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (shf_clear),
        .sample_i   (sample),
        .bit_i      (rx_bit),
        .len_i      (eff_len),
        .msb_first_i(s_q.ctrl.msb_first),
        .done_o     (frame_done),
        .frame_o    (frame_val)
    );

    always_comb begin
        if (s_q.len_f < LEN_W'(MIN_LEN))      eff_len = LEN_W'(MIN_LEN);
        else if (s_q.len_f > LEN_W'(MAX_LEN)) eff_len = LEN_W'(MAX_LEN);
        else                                  eff_len = s_q.len_f;

        data_rd   = reg_rd && (reg_addr_e'(reg_addr) == ADR_DATA);
        mst_start = s_q.ctrl.master && s_q.ctrl.rx_en && !s_q.ovr
                    && !s_q.halt && !s_q.active && data_rd;
        if (s_q.ctrl.master) begin
            sample    = s_q.active && m_trail;
            shf_clear = !s_q.active;
            rx_bit    = sdi;
        end else begin
            sample    = s_q.ctrl.rx_en && !s_q.ovr && s_trail;
            shf_clear = !s_q.ctrl.rx_en || s_q.ovr;
            rx_bit    = s_sdi;
        end

        s_d = s_q;
        if (reg_wr) begin
            case (reg_addr_e'(reg_addr))
                ADR_STAT: if (!reg_wdata[1]) s_d.ovr = 1'b0;
                ADR_CTRL: s_d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
                ADR_FMT: begin
                    s_d.len_f = reg_wdata[LEN_W-1:0];
                    s_d.half  = reg_wdata[DIV_LSB +: DIV_W];
                end
                default: ;
            endcase
        end
        if (data_rd) s_d.ready = 1'b0;
        if (frame_done) begin
            if (s_q.ready && !data_rd) begin
                s_d.ovr = 1'b1;
            end else begin
                s_d.data  = frame_val;
                s_d.ready = 1'b1;
            end
        end

        if (!s_q.ctrl.master)                     s_d.active = 1'b0;
        else if (mst_start)                       s_d.active = 1'b1;
        else if (frame_done)                      s_d.active = 1'b0;

        if (frame_done && s_q.ctrl.master && s_q.ctrl.stop_after)
            s_d.halt = 1'b1;
        else if (!s_q.ctrl.rx_en && !s_q.ctrl.stop_after)
            s_d.halt = 1'b0;

        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            ADR_DATA: reg_rdata[MAX_LEN-1:0] = s_q.data;
            ADR_STAT: reg_rdata[1:0] = {s_q.ovr, s_q.ready};
            ADR_CTRL: reg_rdata[CTRL_W-1:0] = s_q.ctrl;
            ADR_FMT: begin
                reg_rdata[LEN_W-1:0]         = s_q.len_f;
                reg_rdata[DIV_LSB +: DIV_W] = s_q.half;
            end
            default: ;
        endcase
        sck_oe  = s_q.ctrl.master;
        rx_irq  = s_q.ready && s_q.ctrl.irq_en;
        ovr_irq = s_q.ovr && s_q.ctrl.irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5
    rd_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !frame_done) |=> !s_q.ready);

    // R8
    ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ovr) |-> $stable(s_q.data));

    // R9
    ovr_blocks_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovr && !s_q.active) |=> !frame_done);

    // R7
    halt_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.halt |=> !s_q.active);

    // R10
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |-> (sck_out == s_q.ctrl.idle_high));
endmodule

// File: tb/ssr_rx_ctrl_tb_top.sv
`timescale 1ns/1ps
module ssr_rx_ctrl_tb_top;
    localparam int WD_CYCLES = 150000;
    localparam logic [15:0] C_RXEN = 16'h01, C_IRQ = 16'h02, C_STOP = 16'h04,
                            C_MST = 16'h08, C_MSB = 16'h10, C_IDLEH = 16'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sck_in = 1'b0, sdi = 1'b0;
    logic        sck_out, sck_oe, rx_irq, ovr_irq;
    logic        cur_idle = 1'b0;
    int          n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    ssr_rx_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck_in(sck_in), .sdi(sdi), .sck_out(sck_out), .sck_oe(sck_oe),
        .rx_irq(rx_irq), .ovr_irq(ovr_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input logic [15:0] seq, input int len, input bit msb);
        logic [15:0] r = '0;
        for (int i = 0; i < len; i++) begin
            if (msb) r[len-1-i] = seq[i];
            else     r[i] = seq[i];
        end
        return r;
    endfunction

    function automatic int clamp_len(input int f);
        return (f < 8) ? 8 : (f > 16) ? 16 : f;
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // remote transmitter for master mode: next bit on each leaving-idle edge
    task automatic mst_run(input logic [15:0] seq, input int half,
                           output int leads, output int bad_iv);
        logic prev = cur_idle;
        int quiet = 0, t = 0, last_t = -1;
        leads = 0; bad_iv = 0;
        while (quiet < 8 * (half + 1) + 20) begin
            @(negedge clk);
            t++;
            if (sck_out !== prev) begin
                if (last_t >= 0 && (t - last_t) != half + 1) bad_iv++;
                last_t = t;
                quiet = 0;
                if (sck_out !== cur_idle) begin
                    sdi = (leads < 16) ? seq[leads] : 1'b0;
                    leads++;
                end
            end else begin
                quiet++;
            end
            prev = sck_out;
        end
    endtask

    task automatic slv_frame(input logic [15:0] seq, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sdi = seq[i];
            repeat (3) @(negedge clk);
            sck_in = ~cur_idle;
            repeat (3) @(negedge clk);
            sck_in = cur_idle;
            repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rd, s1, s2, s3, s4;
        int leads, biv, seed;
        seed = $urandom(32'h5eed_1234);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), rd);
            check("R1 reg", {16'd0, rd}, 32'd0);
        end
        check("R1 sck_out", {31'd0, sck_out}, 32'd0);
        check("R1 sck_oe", {31'd0, sck_oe}, 32'd0);
        check("R1 irqs", {30'd0, rx_irq, ovr_irq}, 32'd0);

        // master, LSB first, length 8, half period 4 cycles
        cur_idle = 1'b0;
        reg_write(2'd3, 16'h0308);
        reg_write(2'd2, C_RXEN | C_IRQ | C_MST);
        check("R2 sck_oe", {31'd0, sck_oe}, 32'd1);
        s1 = 16'($urandom); s2 = 16'($urandom); s3 = 16'($urandom); s4 = 16'($urandom);
        reg_read(2'd0, rd);                       // dummy read
        mst_run(s1, 3, leads, biv);
        check("R2 pulses", leads, 8);
        check("R10 half period", biv, 0);
        reg_read(2'd1, rd);
        check("R3 ready", {16'd0, rd}, 32'd1);
        check("R4 rx_irq set", {31'd0, rx_irq}, 32'd1);
        reg_read(2'd0, rd);                       // collect + restart
        check("R3 data lsb", {16'd0, rd}, {16'd0, exp_word(s1, 8, 0)});
        reg_read(2'd1, rd);
        check("R5 ready cleared", {16'd0, rd}, 32'd0);
        check("R4 rx_irq clear", {31'd0, rx_irq}, 32'd0);
        mst_run(s2, 3, leads, biv);
        check("R6 restart pulses", leads, 8);

        // R7 stop after frame
        reg_write(2'd2, C_RXEN | C_IRQ | C_MST | C_STOP);
        reg_read(2'd0, rd);
        check("R6 data", {16'd0, rd}, {16'd0, exp_word(s2, 8, 0)});
        mst_run(s3, 3, leads, biv);
        check("R7 last frame pulses", leads, 8);
        reg_read(2'd0, rd);
        check("R7 last data", {16'd0, rd}, {16'd0, exp_word(s3, 8, 0)});
        mst_run(16'h0, 3, leads, biv);
        check("R7 halted after read", leads, 0);
        reg_write(2'd2, C_RXEN | C_IRQ | C_MST);
        reg_read(2'd0, rd);
        mst_run(16'h0, 3, leads, biv);
        check("R7 still halted with enable on", leads, 0);
        reg_write(2'd2, C_MST);
        reg_write(2'd2, C_RXEN | C_IRQ | C_MST);
        reg_read(2'd0, rd);
        mst_run(s4, 3, leads, biv);
        check("R7 restart after release", leads, 8);
        reg_write(2'd2, C_MST | C_IRQ);
        reg_read(2'd0, rd);
        check("R3 data after release", {16'd0, rd}, {16'd0, exp_word(s4, 8, 0)});
        mst_run(16'h0, 3, leads, biv);
        check("R2 no start when disabled", leads, 0);

        // random master configurations, last two with out-of-range lengths
        for (int it = 0; it < 8; it++) begin
            int lf, el, half;
            bit msb, idl;
            logic [15:0] cfg, sq;
            lf   = (it == 6) ? 3 : (it == 7) ? 25 : 8 + int'($urandom % 9);
            el   = clamp_len(lf);
            half = int'($urandom % 4);
            msb  = 1'($urandom);
            idl  = 1'($urandom);
            sq   = 16'($urandom);
            cfg  = C_RXEN | C_IRQ | C_MST | (msb ? C_MSB : 16'h0) | (idl ? C_IDLEH : 16'h0);
            reg_write(2'd3, 16'((half << 8) | lf));
            reg_write(2'd2, cfg);
            cur_idle = idl;
            @(negedge clk);
            check("R10 idle level", {31'd0, sck_out}, {31'd0, idl});
            reg_read(2'd0, rd);
            mst_run(sq, half, leads, biv);
            if (it >= 6) check("R12 clamped pulses", leads, el);
            else         check("R2 pulses", leads, el);
            check("R10 half period", biv, 0);
            reg_write(2'd2, cfg & ~C_RXEN);
            reg_read(2'd0, rd);
            if (it >= 6) check("R12 clamped data", {16'd0, rd}, {16'd0, exp_word(sq, el, msb)});
            else         check("R3 data order", {16'd0, rd}, {16'd0, exp_word(sq, el, msb)});
        end

        // slave mode, LSB first, idle low, length 8
        cur_idle = 1'b0; sck_in = 1'b0;
        reg_write(2'd3, 16'h0008);
        reg_write(2'd2, C_RXEN | C_IRQ);
        check("R2 sck_oe slave", {31'd0, sck_oe}, 32'd0);
        repeat (4) @(negedge clk);
        s1 = 16'($urandom); s2 = ~s1; s3 = 16'($urandom); s4 = 16'($urandom);
        slv_frame(s1, 8);
        reg_read(2'd1, rd);
        check("R3 slave ready", {16'd0, rd}, 32'd1);
        slv_frame(s2, 8);
        reg_read(2'd1, rd);
        check("R8 overrun flag", {16'd0, rd}, 32'd3);
        check("R8 ovr_irq", {31'd0, ovr_irq}, 32'd1);
        reg_read(2'd0, rd);
        check("R8 data kept", {16'd0, rd}, {16'd0, exp_word(s1, 8, 0)});
        slv_frame(s3, 8);
        reg_read(2'd1, rd);
        check("R9 no rx in overrun", {16'd0, rd}, 32'd2);
        reg_write(2'd1, 16'h0002);
        reg_read(2'd1, rd);
        check("R9 write one keeps flag", {16'd0, rd}, 32'd2);
        reg_write(2'd1, 16'h0000);
        reg_read(2'd1, rd);
        check("R9 flag cleared", {16'd0, rd}, 32'd0);
        check("R4 ovr_irq clear", {31'd0, ovr_irq}, 32'd0);
        slv_frame(s4, 8);
        reg_read(2'd0, rd);
        check("R9 resumed data", {16'd0, rd}, {16'd0, exp_word(s4, 8, 0)});

        // slave, MSB first, idle high, length 10
        sck_in = 1'b1;
        repeat (5) @(negedge clk);
        reg_write(2'd3, 16'h000A);
        reg_write(2'd2, C_RXEN | C_IRQ | C_MSB | C_IDLEH);
        cur_idle = 1'b1;
        s1 = 16'($urandom); s2 = 16'($urandom); s3 = 16'($urandom);
        slv_frame(s1, 10);
        reg_read(2'd0, rd);
        check("R10 slave idle high msb", {16'd0, rd}, {16'd0, exp_word(s1, 10, 1)});
        slv_frame(16'h5555, 4);                   // partial frame
        reg_write(2'd2, C_IRQ | C_MSB | C_IDLEH);
        slv_frame(s2, 10);
        reg_read(2'd1, rd);
        check("R11 disabled ignores edges", {16'd0, rd}, 32'd0);
        reg_write(2'd2, C_RXEN | C_IRQ | C_MSB | C_IDLEH);
        slv_frame(s3, 10);
        reg_read(2'd0, rd);
        check("R11 fresh frame", {16'd0, rd}, {16'd0, exp_word(s3, 10, 1)});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule